// File: doc/BRIEF.md
# Multi-Ratio Clock Divider with Coincidence Sync

This block takes one fast clock and divides it into two output banks, A and C, and a separate feedback clock. A 4-bit frequency select sets the A and C dividers, which gives 16 ratio configurations. These include non-binary pairs such as 3:2 and 4:3. A 3-bit feedback select picks the feedback divider on its own. A coincidence detector raises a one-cycle SYNC pulse just before each rising edge that banks A and C share. A third bank, D, carries either that SYNC pulse or a copy of bank C.

The input clock can be a VCO-rate clock or a slow test clock. Either way every output edge comes from the dividers, so one output transition can take several input edges. The block reads all select inputs at the moment reset is released. After that they have no effect until the next reset. An active-low master reset clears every divider together, so the outputs restart with aligned rising edges.

Top module: `ratio_clkdiv`

## Requirements
- R1: While `rst_n` is low, `qa`, `qc`, `qd`, `qfb` and `sync` are all 0.
- R2: Bank A divides the input clock by N = 2, 3, 4 or 6 for `fsel[1:0]` = 0, 1, 2 or 3. Count input cycles k from 0, where cycle 0 is the first cycle after the first rising edge with `rst_n` high. Then `qa` is 1 when (k mod N) < floor(N/2) and 0 otherwise. For N=3 this gives a duty cycle of 1/3.
- R3: Bank C divides by N = 2, 4, 6 or 8 for `fsel[3:2]` = 0, 1, 2 or 3. It uses the same phase rule as R2.
- R4: The feedback output `qfb` divides by N = 2, 4, 6, 8 or 12 for `fbsel` = 0 to 4, and by 16 for `fbsel` = 5, 6 or 7. It uses the same phase rule as R2.
- R5: In cycle 0 after reset release, `qa`, `qc` and `qfb` all go high together.
- R6: `sync` is 1 in cycle k exactly when cycle k+1 starts a new period of both bank A and bank C. Each pulse lasts one input cycle and is followed by a shared rise of `qa` and `qc`.
- R7: If `sync_sel` was 1 when sampled, `qd` equals `sync`. If it was 0, `qd` equals `qc`.
- R8: `fsel`, `fbsel` and `sync_sel` are sampled on the first rising clock edge with `rst_n` high. Later changes have no effect on any output until the next reset.
- R9: Asserting `rst_n` in the middle of a run stops all outputs. The next release restarts every divider at phase 0, using the newly sampled selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (VCO rate or test clock) |
| rst_n | input | 1 | Asynchronous active-low master reset |
| fsel | input | 4 | Bank ratio select: [1:0] sets bank A, [3:2] sets bank C |
| fbsel | input | 3 | Feedback divide select |
| sync_sel | input | 1 | Bank D source: 1 selects sync, 0 selects a copy of bank C |
| qa | output | 1 | Bank A clock |
| qc | output | 1 | Bank C clock |
| qd | output | 1 | Bank D output |
| qfb | output | 1 | Feedback clock |
| sync | output | 1 | Coincidence pulse ahead of shared A/C rising edges |

## Verification
The bench builds the block with its default counter width of 5 bits. This width holds every divide value up to 16, so all 16 frequency configurations and all 8 feedback codes can be reached. Each configuration runs for 48 cycles, a common multiple of every A/C pair and the 16-cycle feedback period. This lets the model see several coincidence pulses per run and, for 6:8, the full alignment cycle. Every run is started by a reset in the middle of the previous run. In some runs the selects are flipped partway through, to show they are held until the next reset.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

   localparam int MAX_DIV = 16;

   typedef struct packed {
      logic [1:0] c_sel;
      logic [1:0] a_sel;
      logic [2:0] fb_sel;
      logic       qd_sync;
   } rcd_cfg_t;

   localparam int CFG_W = $bits(rcd_cfg_t);

   function automatic int a_div(input logic [1:0] s);
      case (s)
         2'd0:    return 2;
         2'd1:    return 3;
         2'd2:    return 4;
         default: return 6;
      endcase
   endfunction

   function automatic int c_div(input logic [1:0] s);
      return 2 * (int'(s) + 1);
   endfunction

   function automatic int fb_div(input logic [2:0] s);
      case (s)
         3'd0:    return 2;
         3'd1:    return 4;
         3'd2:    return 6;
         3'd3:    return 8;
         3'd4:    return 12;
         default: return MAX_DIV;
      endcase
   endfunction

endpackage

// File: rtl/rcd_cfg.sv
module rcd_cfg
   import rcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] fsel,
   input  logic [2:0] fbsel,
   input  logic       sync_sel,
   output logic       run,
   output rcd_cfg_t   cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cfg <= '0;
      end else begin
         run <= 1'b1;
         if (!run) begin
            cfg.c_sel   <= fsel[3:2];
            cfg.a_sel   <= fsel[1:0];
            cfg.fb_sel  <= fbsel;
            cfg.qd_sync <= sync_sel;
         end
      end
   end

endmodule

// File: rtl/rcd_div.sv
module rcd_div #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] div,
   output logic             q,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half;

   assign half = div >> 1;
   assign wrap = run && (cnt == div - CNT_W'(1));
   assign q    = run && (cnt < half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= wrap ? '0 : cnt + CNT_W'(1);
   end

endmodule

// File: rtl/rcd_sync.sv
module rcd_sync (
   input  logic run,
   input  logic a_wrap,
   input  logic c_wrap,
   input  logic qc,
   input  logic qd_sync,
   output logic sync,
   output logic qd
);

   assign sync = run && a_wrap && c_wrap;
   assign qd   = qd_sync ? sync : qc;

endmodule

// File: rtl/ratio_clkdiv.sv
module ratio_clkdiv
   import rcd_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] fsel,
   input  logic [2:0] fbsel,
   input  logic       sync_sel,
   output logic       qa,
   output logic       qc,
   output logic       qd,
   output logic       qfb,
   output logic       sync
);

   localparam int NUM_DIV = 3;
   localparam int IDX_A   = 0;
   localparam int IDX_C   = 1;
   localparam int IDX_FB  = 2;
   localparam int MIN_W   = $clog2(MAX_DIV + 1);

   if (CNT_W < MIN_W) begin : g_bad_width
      $error("ratio_clkdiv: CNT_W too small for largest divide value");
   end

   logic             run_q;
   rcd_cfg_t         cfg_q;
   logic [CNT_W-1:0] div_v  [NUM_DIV];
   logic [NUM_DIV-1:0] q_v;
   logic [NUM_DIV-1:0] wrap_v;

   rcd_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsel     (fsel),
      .fbsel    (fbsel),
      .sync_sel (sync_sel),
      .run      (run_q),
      .cfg      (cfg_q)
   );

   always_comb begin
      div_v[IDX_A]  = CNT_W'(a_div(cfg_q.a_sel));
      div_v[IDX_C]  = CNT_W'(c_div(cfg_q.c_sel));
      div_v[IDX_FB] = CNT_W'(fb_div(cfg_q.fb_sel));
   end

   for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      rcd_div #(.CNT_W(CNT_W)) u_div (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (run_q),
         .div   (div_v[g]),
         .q     (q_v[g]),
         .wrap  (wrap_v[g])
      );
   end

   rcd_sync u_sync (
      .run     (run_q),
      .a_wrap  (wrap_v[IDX_A]),
      .c_wrap  (wrap_v[IDX_C]),
      .qc      (q_v[IDX_C]),
      .qd_sync (cfg_q.qd_sync),
      .sync    (sync),
      .qd      (qd)
   );

   assign qa  = q_v[IDX_A];
   assign qc  = q_v[IDX_C];
   assign qfb = q_v[IDX_FB];

endmodule

// File: rtl/rcd_chk.sv
module rcd_chk
   import rcd_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CFG_W-1:0] cfg,
   input logic             qa,
   input logic             qc,
   input logic             qd,
   input logic             qfb,
   input logic             sync
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      (!rst_n && $past(!rst_n)) |-> (!qa && !qc && !qd && !qfb && !sync)); // R1

   AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (qa && qc && qfb)); // R5

   AST_SYNC_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> !sync); // R6

   AST_SYNC_THEN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> ($rose(qa) && $rose(qc))); // R6

   AST_QD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      qd |-> (qc || sync)); // R7

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(cfg)); // R8

endmodule

bind ratio_clkdiv rcd_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .run   (run_q),
   .cfg   (cfg_q),
   .qa    (qa),
   .qc    (qc),
   .qd    (qd),
   .qfb   (qfb),
   .sync  (sync)
);

// File: tb/ratio_clkdiv_tb.sv
module ratio_clkdiv_tb;

   localparam int CLK_P  = 10;
   localparam int RUN_CY = 48;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [3:0] fsel = '0;
   logic [2:0] fbsel = '0;
   logic       sync_sel = 1'b0;
   logic       qa, qc, qd, qfb, sync;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ratio_clkdiv u_dut (
      .clk(clk), .rst_n(rst_n), .fsel(fsel), .fbsel(fbsel), .sync_sel(sync_sel),
      .qa(qa), .qc(qc), .qd(qd), .qfb(qfb), .sync(sync)
   );

   function automatic int exp_a(input int s);
      int t[4] = '{2, 3, 4, 6};
      return t[s];
   endfunction

   function automatic int exp_c(input int s);
      int t[4] = '{2, 4, 6, 8};
      return t[s];
   endfunction

   function automatic int exp_fb(input int s);
      int t[8] = '{2, 4, 6, 8, 12, 16, 16, 16};
      return t[s];
   endfunction

   function automatic bit phase_hi(input int k, input int n);
      return (k % n) < (n / 2);
   endfunction

   task automatic chk(input string req, input string sig, input bit got, input bit exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s got=%0b exp=%0b at %0t", req, sig, got, exp, $time);
      end
   endtask

   task automatic run_cfg(input int fs, input int fb, input bit ss, input bit flip, input bit first);
      int da, dc, dfb;
      bit ea, ec, ef, es;
      da  = exp_a(fs % 4);
      dc  = exp_c(fs / 4);
      dfb = exp_fb(fb);
      @(negedge clk);
      rst_n    = 1'b0;
      fsel     = 4'(fs);
      fbsel    = 3'(fb);
      sync_sel = ss;
      @(negedge clk);
      chk("R1", "qa", qa, 1'b0);
      chk("R1", "qc", qc, 1'b0);
      chk("R1", "qd", qd, 1'b0);
      chk("R1", "qfb", qfb, 1'b0);
      chk("R1", "sync", sync, 1'b0);
      rst_n = 1'b1;
      for (int k = 0; k < RUN_CY; k++) begin
         @(negedge clk);
         ea = phase_hi(k, da);
         ec = phase_hi(k, dc);
         ef = phase_hi(k, dfb);
         es = (((k + 1) % da) == 0) && (((k + 1) % dc) == 0);
         if (k == 0) begin
            // R5 aligned start; R9 realignment after reset mid-run
            chk(first ? "R5" : "R9", "qa start", qa, 1'b1);
            chk("R5", "qc start", qc, 1'b1);
            chk("R5", "qfb start", qfb, 1'b1);
         end
         chk(flip ? "R8" : "R2", "qa", qa, ea);
         chk(flip ? "R8" : "R3", "qc", qc, ec);
         chk(flip ? "R8" : "R4", "qfb", qfb, ef);
         chk("R6", "sync", sync, es);
         chk("R7", "qd", qd, ss ? es : ec);
         if (flip && k == RUN_CY / 3) begin
            fsel     = ~fsel;
            fbsel    = ~fbsel;
            sync_sel = ~sync_sel;
         end
      end
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         run_cfg(i, i % 8, i[0], (i % 4) == 3, i == 0);
      end
      run_cfg(6, 5, 1'b1, 1'b1, 1'b0);
      run_cfg(1, 4, 1'b0, 1'b0, 1'b0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule